// File: doc/BRIEF.md
# Multiplexed Pixel Palette Lookup Serializer

This block sits between a slow, wide pixel bus and a fast colour output. On each rising edge of a load strobe it captures a group of pixel slots in parallel: four or five 8-bit palette indices, a 2-bit overlay select per slot and one blank flag. The strobe runs at a quarter or a fifth of the pixel clock. It may have any phase relative to that clock. The strobe is brought into the pixel clock domain, and each detected edge takes a snapshot of the captured group. The block then issues one colour per pixel clock, slot A first and slot E (or D) last.

Each colour comes from a 256-word by 24-bit palette RAM or from a small bank of overlay registers. A blanked group gives black. A reduced-depth mode clears the low nibble of every component. Both tables are loaded through a simple synchronous write port in the pixel clock domain. The output of the lookup pipeline is registered. Each beat is marked with a valid flag.

Top module: `pixel_mux_palette`

## Requirements
- R1: After reset, and in every cycle where `out_valid` is 0, `out_valid`, `out_r`, `out_g` and `out_b` are all 0.
- R2: Each rising edge of `ld` produces exactly one burst of consecutive valid beats, in slot order A, B, C, D (, E). A burst has 4 beats when `five_mode` is 0 and 5 beats when it is 1. Slot k uses `pix_addr[8k+7:8k]` and `ovl_sel[2k+1:2k]`.
- R3: A palette beat outputs the 24-bit word stored at the slot's index, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: When `ovl_en` is 1 and the slot's overlay select is nonzero, the beat outputs the overlay register that the select value names. The slot's palette index has no effect on that beat.
- R5: When the overlay select is 0, or when `ovl_en` is 0, the beat comes from the palette. This holds whatever the overlay register contents are.
- R6: When `blank_n` was 0 at the strobe edge, every beat of that burst is valid and outputs 0 on all three components.
- R7: When `nib4` is 1, bits 3:0 of each output component are 0 and bits 7:4 keep the looked-up value.
- R8: A write with `wr_en`=1 stores `wr_data` on the next pixel clock edge. It goes to palette word `wr_addr` when `wr_ovl`=0, and to overlay register `wr_addr[1:0]` when `wr_ovl`=1.
- R9: A palette write that lands on the same edge as the lookup of that entry does not change that lookup, which returns the old word. Lookups on later edges return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld | input | 1 | Load strobe; inputs are captured on its rising edge |
| pix_addr | input | 40 | Five 8-bit palette indices, slot A in the low byte |
| ovl_sel | input | 10 | Five 2-bit overlay selects, slot A in the low pair |
| blank_n | input | 1 | Active-low blank for the group |
| five_mode | input | 1 | 1: five slots per load, 0: four |
| ovl_en | input | 1 | Enables overlay override |
| nib4 | input | 1 | Reduced-depth mode, clears component low nibbles |
| wr_en | input | 1 | Table write strobe |
| wr_ovl | input | 1 | Write target: 0 palette, 1 overlay bank |
| wr_addr | input | 8 | Write address |
| wr_data | input | 24 | Write data, red in bits 23:16 |
| out_valid | output | 1 | Marks a colour beat |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
Two things can happen on the same pixel clock edge: a table write and the palette read of the same entry. The bench loads groups back to back so that the bursts run without a gap. It finds the first valid beat and from it derives the edge on which slot A of the next burst reads its entry. It then places a write to that entry on that exact edge. Slots A and B share one index. Slot A must return the old word and slot B, read one edge later, must return the new one.

// File: rtl/pixel_mux_palette.sv
module pixel_mux_palette #(
  parameter int PIX_W  = 8,
  parameter int OVL_W  = 2,
  parameter int SLOTS  = 5,
  parameter int COMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic [SLOTS*PIX_W-1:0]   pix_addr,
  input  logic [SLOTS*OVL_W-1:0]   ovl_sel,
  input  logic                     blank_n,
  input  logic                     five_mode,
  input  logic                     ovl_en,
  input  logic                     nib4,
  input  logic                     wr_en,
  input  logic                     wr_ovl,
  input  logic [PIX_W-1:0]         wr_addr,
  input  logic [3*COMP_W-1:0]      wr_data,
  output logic                     out_valid,
  output logic [COMP_W-1:0]        out_r,
  output logic [COMP_W-1:0]        out_g,
  output logic [COMP_W-1:0]        out_b
);
  localparam int WORD_W = 3 * COMP_W;
  localparam int DEPTH  = 1 << PIX_W;
  localparam int NOVL   = 1 << OVL_W;
  localparam int CNT_W  = $clog2(SLOTS);

  function automatic logic [WORD_W-1:0] nib_mask_f();
    logic [WORD_W-1:0] m;
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < COMP_W; b++)
        m[c*COMP_W+b] = (b >= COMP_W/2);
    return m;
  endfunction
  localparam logic [WORD_W-1:0] NIB_MASK = nib_mask_f();

  // load-strobe domain capture
  logic [SLOTS*PIX_W-1:0] l_pix;
  logic [SLOTS*OVL_W-1:0] l_ovl;
  logic                   l_blank_n;

  always_ff @(posedge ld or negedge rst_n) begin
    if (!rst_n) begin
      l_pix     <= '0;
      l_ovl     <= '0;
      l_blank_n <= 1'b0;
    end else begin
      l_pix     <= pix_addr;
      l_ovl     <= ovl_sel;
      l_blank_n <= blank_n;
    end
  end

  // strobe synchroniser and edge detect
  logic [2:0] ld_sync;
  logic       start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_sync <= '0;
    else        ld_sync <= {ld_sync[1:0], ld};
  end
  assign start = ld_sync[1] & ~ld_sync[2];

  // snapshot and slot sequencer
  logic [SLOTS*PIX_W-1:0] s_pix;
  logic [SLOTS*OVL_W-1:0] s_ovl;
  logic                   s_blank_n;
  logic [CNT_W-1:0]       s_last;
  logic                   sel_valid;
  logic [CNT_W-1:0]       sel_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pix     <= '0;
      s_ovl     <= '0;
      s_blank_n <= 1'b0;
      s_last    <= '0;
      sel_valid <= 1'b0;
      sel_slot  <= '0;
    end else if (start) begin
      s_pix     <= l_pix;
      s_ovl     <= l_ovl;
      s_blank_n <= l_blank_n;
      s_last    <= five_mode ? CNT_W'(SLOTS-1) : CNT_W'(SLOTS-2);
      sel_valid <= 1'b1;
      sel_slot  <= '0;
    end else if (sel_valid) begin
      if (sel_slot == s_last) sel_valid <= 1'b0;
      else                    sel_slot  <= sel_slot + CNT_W'(1);
    end
  end

  logic [PIX_W-1:0] cur_addr;
  logic [OVL_W-1:0] cur_ovl;
  assign cur_addr = s_pix[int'(sel_slot)*PIX_W +: PIX_W];
  assign cur_ovl  = s_ovl[int'(sel_slot)*OVL_W +: OVL_W];

  // tables
  logic [WORD_W-1:0] pal_mem [DEPTH];
  logic [WORD_W-1:0] ovl_reg [NOVL];

  always_ff @(posedge clk)
    if (wr_en && !wr_ovl) pal_mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NOVL; i++) ovl_reg[i] <= '0;
    end else if (wr_en && wr_ovl) begin
      ovl_reg[wr_addr[OVL_W-1:0]] <= wr_data;
    end
  end

  // lookup stage
  logic              p1_valid, p1_use_ovl, p1_blank_n;
  logic [WORD_W-1:0] p1_pal, p1_ovl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_valid   <= 1'b0;
      p1_use_ovl <= 1'b0;
      p1_blank_n <= 1'b0;
      p1_pal     <= '0;
      p1_ovl     <= '0;
    end else begin
      p1_valid   <= sel_valid;
      p1_use_ovl <= ovl_en && (cur_ovl != '0);
      p1_blank_n <= s_blank_n;
      p1_pal     <= pal_mem[cur_addr];
      p1_ovl     <= ovl_reg[cur_ovl];
    end
  end

  // output stage
  logic [WORD_W-1:0] out_word;
  logic [WORD_W-1:0] mask;
  assign mask = nib4 ? NIB_MASK : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= p1_valid;
      out_word  <= (p1_valid && p1_blank_n) ?
                   ((p1_use_ovl ? p1_ovl : p1_pal) & mask) : '0;
    end
  end

  assign out_r = out_word[3*COMP_W-1:2*COMP_W];
  assign out_g = out_word[2*COMP_W-1:COMP_W];
  assign out_b = out_word[COMP_W-1:0];
endmodule

module pixel_mux_palette_chk #(
  parameter int CNT_W  = 3,
  parameter int COMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              sel_valid,
  input logic [CNT_W-1:0]  sel_slot,
  input logic [CNT_W-1:0]  s_last,
  input logic              s_blank_n,
  input logic              nib4,
  input logic              out_valid,
  input logic [COMP_W-1:0] out_r,
  input logic [COMP_W-1:0] out_g,
  input logic [COMP_W-1:0] out_b
);
  localparam int H = COMP_W / 2;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_r == '0 && out_g == '0 && out_b == '0));

  assert_start_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sel_valid && sel_slot == '0));

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_slot <= s_last));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !start && sel_slot != s_last) |=>
      (sel_valid && sel_slot == $past(sel_slot) + CNT_W'(1)));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ##2 out_valid);

  assert_blank_black_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !s_blank_n) |-> ##2 (out_valid && out_r == '0 && out_g == '0 && out_b == '0));

  assert_low_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(nib4)) |->
      (out_r[H-1:0] == '0 && out_g[H-1:0] == '0 && out_b[H-1:0] == '0));
endmodule

bind pixel_mux_palette pixel_mux_palette_chk #(.CNT_W(CNT_W), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sel_valid(sel_valid),
  .sel_slot(sel_slot), .s_last(s_last), .s_blank_n(s_blank_n), .nib4(nib4),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/pixel_mux_palette_tb.sv
module pixel_mux_palette_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [39:0] pix_addr = '0;
  logic [9:0]  ovl_sel = '0;
  logic        blank_n = 1'b1;
  logic        five_mode = 1'b0;
  logic        ovl_en = 1'b0;
  logic        nib4 = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_ovl = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  pixel_mux_palette u_dut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .pix_addr(pix_addr), .ovl_sel(ovl_sel),
    .blank_n(blank_n), .five_mode(five_mode), .ovl_en(ovl_en), .nib4(nib4),
    .wr_en(wr_en), .wr_ovl(wr_ovl), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit sb_on = 1'b1;
  bit done = 1'b0;
  string tag = "R1";
  logic [23:0] pal_m [256];
  logic [23:0] ovl_m [4];
  logic [23:0] exp_q [$];

  function automatic logic [23:0] expect_word(logic [7:0] a, logic [1:0] o, logic bn);
    logic [23:0] w;
    if (!bn) return 24'h0;
    w = (ovl_en && o != 2'd0) ? ovl_m[o] : pal_m[a];
    if (nib4) w = w & 24'hF0F0F0;
    return w;
  endfunction

  task automatic check(string req, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic o, logic [7:0] a, logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ovl = o; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (o) ovl_m[a[1:0]] = d; else pal_m[a] = d;
  endtask

  task automatic load_group(logic [39:0] a, logic [9:0] o, logic bn, bit push);
    int n = five_mode ? 5 : 4;
    if (push)
      for (int k = 0; k < n; k++) exp_q.push_back(expect_word(a[8*k +: 8], o[2*k +: 2], bn));
    @(negedge clk);
    pix_addr = a; ovl_sel = o; blank_n = bn;
    ld = 1'b1;
    repeat (2) @(negedge clk);
    ld = 1'b0;
    repeat (n - 3) @(negedge clk);
  endtask

  task automatic drain(string req);
    repeat (12) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s beats missing got %0d expected 0 left", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s unexpected beat got %h expected none", tag, {out_r, out_g, out_b});
        end else begin
          check(tag, {out_r, out_g, out_b}, exp_q.pop_front());
        end
      end else begin
        check("R1", {out_r, out_g, out_b}, 24'h0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {7'd0, out_valid, out_r, out_g, out_b}, 32'h0);
    rst_n = 1'b1;
    sb_on = 1'b0;
    for (int i = 0; i < 256; i++)
      wr(1'b0, 8'(i), {8'(i) ^ 8'h5A, 8'(i * 3), ~8'(i)});
    wr(1'b1, 8'd1, 24'h112233);
    wr(1'b1, 8'd2, 24'hA0B0C0);
    wr(1'b1, 8'd3, 24'hFEDCBA);
    repeat (4) @(negedge clk);
    sb_on = 1'b1;

    // R2 R3: four-slot bursts, back to back
    tag = "R3";
    load_group(40'h00_04_03_02_01, 10'h0, 1'b1, 1'b1);
    load_group(40'h55_FF_80_7F_00, 10'h0, 1'b1, 1'b1);
    load_group(40'h99_10_20_30_40, 10'h0, 1'b1, 1'b1);
    drain("R2");

    // R2: five-slot bursts
    tag = "R2";
    five_mode = 1'b1;
    load_group(40'hE5_D4_C3_B2_A1, 10'h0, 1'b1, 1'b1);
    load_group(40'h01_02_03_04_05, 10'h0, 1'b1, 1'b1);
    drain("R2");

    // R4: overlay override, palette index ignored
    tag = "R4";
    ovl_en = 1'b1;
    load_group(40'h77_66_55_44_33, {2'd0, 2'd3, 2'd2, 2'd1, 2'd0}, 1'b1, 1'b1);
    load_group(40'hFF_FF_FF_FF_FF, {2'd1, 2'd1, 2'd1, 2'd1, 2'd1}, 1'b1, 1'b1);
    drain("R4");

    // R8: overlay rewrite, then lookup
    tag = "R8";
    wr(1'b1, 8'd2, 24'h0F1E2D);
    load_group(40'h00_00_00_00_00, {2'd2, 2'd0, 2'd2, 2'd0, 2'd2}, 1'b1, 1'b1);
    drain("R8");

    // R5: overlay disabled ignores nonzero selects
    tag = "R5";
    ovl_en = 1'b0;
    five_mode = 1'b0;
    load_group(40'h00_12_34_56_78, {2'd3, 2'd3, 2'd2, 2'd1, 2'd3}, 1'b1, 1'b1);
    drain("R5");

    // R6: blank burst between normal ones
    tag = "R6";
    ovl_en = 1'b1;
    load_group(40'h00_0A_0B_0C_0D, 10'h0, 1'b1, 1'b1);
    load_group(40'h00_0A_0B_0C_0D, {2'd0, 2'd1, 2'd2, 2'd3, 2'd1}, 1'b0, 1'b1);
    load_group(40'h00_0E_0F_10_11, 10'h0, 1'b1, 1'b1);
    drain("R6");

    // R7: reduced depth, palette and overlay
    tag = "R7";
    nib4 = 1'b1;
    five_mode = 1'b1;
    load_group(40'h3C_2B_1A_09_F8, {2'd0, 2'd3, 2'd0, 2'd0, 2'd0}, 1'b1, 1'b1);
    drain("R7");
    nib4 = 1'b0;
    ovl_en = 1'b0;
    five_mode = 1'b0;

    // R8: palette rewrite while idle
    tag = "R8";
    wr(1'b0, 8'h42, 24'hC0FFEE);
    load_group(40'h00_41_42_43_42, 10'h0, 1'b1, 1'b1);
    drain("R8");

    // R9: write coincides with lookup of the same entry
    wr(1'b0, 8'h20, 24'h123456);
    sb_on = 1'b0;
    fork
      begin
        for (int g = 0; g < 3; g++) load_group(40'h00_21_21_20_20, 10'h0, 1'b1, 1'b0);
      end
      begin
        do @(negedge clk); while (!out_valid);
        check("R9", {out_r, out_g, out_b}, 24'h123456);
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_ovl = 1'b0; wr_addr = 8'h20; wr_data = 24'hABCDEF;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R9", {7'd0, out_valid, out_r, out_g, out_b}, {8'd1, 24'h123456});
        @(negedge clk);
        check("R9", {7'd0, out_valid, out_r, out_g, out_b}, {8'd1, 24'hABCDEF});
      end
    join
    pal_m[8'h20] = 24'hABCDEF;
    repeat (12) @(negedge clk);
    sb_on = 1'b1;
    tag = "R9";
    load_group(40'h00_20_20_20_20, 10'h0, 1'b1, 1'b1);
    drain("R9");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule